// File: doc/BRIEF.md
# Configurable Control-Pin Function Multiplexer

This block drives five general control pins. A configuration code for each pin picks what the pin does. The choices are:

- an RS485 driver enable that follows the UART transmitter;
- an active-low power enable for external logic;
- active-low activity pulses for an LED on host-to-device traffic, on device-to-host traffic, or on either;
- an active-low sleep indicator that follows USB suspend;
- clock outputs at the block clock rate and at one half, one quarter and one eighth of it;
- general-purpose output with a per-pin output enable.

The block runs from the 48 MHz clock. The configuration store and the USB state machine are outside it. They supply the per-pin codes, a flag that marks those codes as loaded, the configured and suspended flags, and one-cycle transfer events.

Activity pulses are stretched by a counter so that they stay visible. A new event during a pulse restarts the full width. All derived clocks stop low while USB is suspended, and the dividers restart from phase zero when suspend ends. Until the configuration is marked loaded, the pins use a fixed default map.

Top module: `ctl_pin_mux`

## Requirements
- R1: While `cfg_valid` is 0, the pins use the default map, whatever `cfg_code` holds: pin 0 is the host-to-device LED (code 2), pin 1 is the device-to-host LED (code 3), pin 2 is the driver enable (code 0), pin 3 is the power enable (code 1) and pin 4 is sleep (code 5). While `cfg_valid` is 1, pin i takes its code from `cfg_code[4*i+3:4*i]`.
- R2: Codes 2, 3 and 4 drive the pin low for exactly `LED_HOLD` cycles. The pulse starts one edge after the sampled event. Code 2 pulses on `out_xfer_evt` (host to device), code 3 pulses on `in_xfer_evt` (device to host) and code 4 pulses on either. The pin is high otherwise.
- R3: An event that arrives while a pulse is running restarts the full `LED_HOLD` width from that event.
- R4: Code 5 (sleep) drives the pin low from the edge after `usb_suspend` is sampled high, and high again on the edge after it is sampled low.
- R5: Code 1 (power enable) is low one edge after `usb_configured`=1 and `usb_suspend`=0 are sampled together. It is high in every other case.
- R6: Code 0 (driver enable) is high one edge after `uart_tx_busy` is sampled high, and low one edge after it is sampled low.
- R7: Codes 7, 8 and 9 output bits 0, 1 and 2 of a 3-bit divider. The divider counts up on every clock and so gives 1/2, 1/4 and 1/8 of the clock rate. From the second edge after `usb_suspend` is sampled high, the divider is held at zero, so these outputs are low. When suspend ends, the divider restarts from zero.
- R8: Code 6 outputs `clk` AND an enable. The enable is updated on each falling edge to the inverse of the registered suspend flag and is 0 in reset. The output is therefore low for the whole of every cycle while suspended.
- R9: Code 10 (GPIO) on pins 0 to 3 sets `pin_out[i]`=`gpio_out[i]` and `pin_oe[i]`=`gpio_oe[i]`. Pin 4 cannot be GPIO and treats code 10 as unrecognised.
- R10: An unrecognised code (11 to 15, or 10 on pin 4) drives the pin high. For every code except GPIO, `pin_oe` is 1.
- R11: After synchronous reset, all stretch counters, the divider, the sampled flags and the clock enable are zero. Under the default map the pins read `pin_out`=5'b11011 and `pin_oe`=5'b11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Per-pin codes have been loaded |
| cfg_code | input | 20 | Function code of pin i at bits 4*i+3:4*i |
| usb_configured | input | 1 | USB device configured |
| usb_suspend | input | 1 | USB suspend state |
| uart_tx_busy | input | 1 | UART transmitter busy, through the last stop bit |
| out_xfer_evt | input | 1 | One-cycle host-to-device transfer event |
| in_xfer_evt | input | 1 | One-cycle device-to-host transfer event |
| gpio_out | input | 4 | GPIO output values for pins 0 to 3 |
| gpio_oe | input | 4 | GPIO output enables for pins 0 to 3 |
| pin_out | output | 5 | Pin output levels |
| pin_oe | output | 5 | Pin output enables |

## Verification
Results fall due at different times after a stimulus:

- Sleep, power enable, driver enable and the LED pulses change at the first rising edge after the input is sampled.
- The dividers freeze at the second rising edge after suspend is sampled.
- The clock-rate output's enable changes at the falling edge after that.
- Codes and GPIO values reach the pins in the same cycle.

The bench keeps a behavioural model built from event timestamps and a run-length integer, updated on both clock edges. It drives inputs 2 ns after the rising edge and compares every pin 1 ns after each rising and each falling edge. This means the clock-rate output is seen both high and low.

// File: rtl/pin_fn_pkg.sv
package pin_fn_pkg;

    localparam int CODE_W = 4;
    localparam int DIV_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        FN_TXEN     = 4'd0,
        FN_PWREN_N  = 4'd1,
        FN_OUTLED_N = 4'd2,
        FN_INLED_N  = 4'd3,
        FN_ANYLED_N = 4'd4,
        FN_SLEEP_N  = 4'd5,
        FN_CLK_X1   = 4'd6,
        FN_CLK_D2   = 4'd7,
        FN_CLK_D4   = 4'd8,
        FN_CLK_D8   = 4'd9,
        FN_GPIO     = 4'd10
    } pin_fn_e;

    localparam logic [CODE_W-1:0] CODE_LAST = FN_GPIO;

    // Function signals offered to every pin selector.
    typedef struct packed {
        logic             txen;
        logic             pwren_n;
        logic [2:0]       led_n;    // 0: host-to-device, 1: device-to-host, 2: either
        logic             sleep_n;
        logic             clk_x1;
        logic [DIV_W-1:0] clk_div;  // bit k: clock / 2^(k+1)
    } fn_sigs_t;

    function automatic logic [CODE_W-1:0] default_code(input int pin);
        case (pin)
            0:       return FN_OUTLED_N;
            1:       return FN_INLED_N;
            2:       return FN_TXEN;
            3:       return FN_PWREN_N;
            default: return FN_SLEEP_N;
        endcase
    endfunction

endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
    parameter int HOLD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    output logic led_n
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (evt)
            remain <= CW'(HOLD);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign led_n = (remain == '0);
endmodule

// File: rtl/clk_div_gate.sv
module clk_div_gate
    import pin_fn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic             clk_x1,
    output logic [DIV_W-1:0] div_q
);
    logic gate_en;

    always_ff @(posedge clk) begin
        if (rst || hold)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // Enable changes only while clk is low, so the gated output never glitches.
    always_ff @(negedge clk) begin
        if (rst)
            gate_en <= 1'b0;
        else
            gate_en <= ~hold;
    end

    assign clk_x1 = clk & gate_en;
endmodule

// File: rtl/pin_select.sv
module pin_select
    import pin_fn_pkg::*;
#(
    parameter bit GPIO_OK = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    input  fn_sigs_t          sigs,
    input  logic              gp_o,
    input  logic              gp_e,
    output logic              o,
    output logic              oe
);
    always_comb begin
        o  = 1'b1;
        oe = 1'b1;
        case (code)
            FN_TXEN:     o = sigs.txen;
            FN_PWREN_N:  o = sigs.pwren_n;
            FN_OUTLED_N: o = sigs.led_n[0];
            FN_INLED_N:  o = sigs.led_n[1];
            FN_ANYLED_N: o = sigs.led_n[2];
            FN_SLEEP_N:  o = sigs.sleep_n;
            FN_CLK_X1:   o = sigs.clk_x1;
            FN_CLK_D2:   o = sigs.clk_div[0];
            FN_CLK_D4:   o = sigs.clk_div[1];
            FN_CLK_D8:   o = sigs.clk_div[2];
            FN_GPIO: begin
                if (GPIO_OK) begin
                    o  = gp_o;
                    oe = gp_e;
                end
            end
            default: o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ctl_pin_mux.sv
module ctl_pin_mux
    import pin_fn_pkg::*;
#(
    parameter int NUM_PINS = 5,
    parameter int NUM_GPIO = 4,
    parameter int LED_HOLD = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_valid,
    input  logic [NUM_PINS*CODE_W-1:0] cfg_code,
    input  logic                       usb_configured,
    input  logic                       usb_suspend,
    input  logic                       uart_tx_busy,
    input  logic                       out_xfer_evt,
    input  logic                       in_xfer_evt,
    input  logic [NUM_GPIO-1:0]        gpio_out,
    input  logic [NUM_GPIO-1:0]        gpio_oe,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe
);
    localparam int NUM_LED = 3;

    logic             sus_q, cfgd_q, txen_q;
    logic [NUM_LED-1:0] led_evt, led_n;
    logic             clk_x1;
    logic [DIV_W-1:0] div_q;
    logic             sleep_n, pwren_n;
    fn_sigs_t         sigs;

    always_ff @(posedge clk) begin
        if (rst) begin
            sus_q  <= 1'b0;
            cfgd_q <= 1'b0;
            txen_q <= 1'b0;
        end else begin
            sus_q  <= usb_suspend;
            cfgd_q <= usb_configured;
            txen_q <= uart_tx_busy;
        end
    end

    assign sleep_n = ~sus_q;
    assign pwren_n = ~(cfgd_q & ~sus_q);

    assign led_evt = {out_xfer_evt | in_xfer_evt, in_xfer_evt, out_xfer_evt};

    for (genvar k = 0; k < NUM_LED; k++) begin : g_led
        led_stretch #(.HOLD(LED_HOLD)) u_led (
            .clk   (clk),
            .rst   (rst),
            .evt   (led_evt[k]),
            .led_n (led_n[k])
        );
    end

    clk_div_gate u_clk (
        .clk    (clk),
        .rst    (rst),
        .hold   (sus_q),
        .clk_x1 (clk_x1),
        .div_q  (div_q)
    );

    always_comb begin
        sigs.txen    = txen_q;
        sigs.pwren_n = pwren_n;
        sigs.led_n   = led_n;
        sigs.sleep_n = sleep_n;
        sigs.clk_x1  = clk_x1;
        sigs.clk_div = div_q;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [CODE_W-1:0] code_eff;
        assign code_eff = cfg_valid ? cfg_code[i*CODE_W +: CODE_W] : default_code(i);

        if (i < NUM_GPIO) begin : g_gp
            pin_select #(.GPIO_OK(1'b1)) u_sel (
                .code (code_eff),
                .sigs (sigs),
                .gp_o (gpio_out[i]),
                .gp_e (gpio_oe[i]),
                .o    (pin_out[i]),
                .oe   (pin_oe[i])
            );
        end else begin : g_nogp
            pin_select #(.GPIO_OK(1'b0)) u_sel (
                .code (code_eff),
                .sigs (sigs),
                .gp_o (1'b0),
                .gp_e (1'b0),
                .o    (pin_out[i]),
                .oe   (pin_oe[i])
            );
        end
    end
endmodule

// File: rtl/ctl_pin_mux_chk.sv
module ctl_pin_mux_chk
    import pin_fn_pkg::*;
#(
    parameter int NUM_PINS = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_valid,
    input logic [NUM_PINS*CODE_W-1:0] cfg_code,
    input logic                       usb_configured,
    input logic                       usb_suspend,
    input logic                       uart_tx_busy,
    input logic                       out_xfer_evt,
    input logic                       in_xfer_evt,
    input logic                       sleep_n,
    input logic                       pwren_n,
    input logic                       txen,
    input logic [2:0]                 led_n,
    input logic [DIV_W-1:0]           div_cnt,
    input logic [NUM_PINS-1:0]        pin_out,
    input logic [NUM_PINS-1:0]        pin_oe
);
    localparam int TOP = NUM_PINS - 1;

    assert_outled_R2: assert property (@(posedge clk) disable iff (rst)
        out_xfer_evt |=> !led_n[0]);
    assert_inled_R2: assert property (@(posedge clk) disable iff (rst)
        in_xfer_evt |=> (!led_n[1] && !led_n[2]));
    assert_sleep_lo_R4: assert property (@(posedge clk) disable iff (rst)
        usb_suspend |=> !sleep_n);
    assert_sleep_hi_R4: assert property (@(posedge clk) disable iff (rst)
        !usb_suspend |=> sleep_n);
    assert_pwren_on_R5: assert property (@(posedge clk) disable iff (rst)
        (usb_configured && !usb_suspend) |=> !pwren_n);
    assert_pwren_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!usb_configured || usb_suspend) |=> pwren_n);
    assert_txen_R6: assert property (@(posedge clk) disable iff (rst)
        uart_tx_busy |=> txen);
    assert_div_stop_R7: assert property (@(posedge clk) disable iff (rst)
        usb_suspend |-> ##2 (div_cnt == '0));
    assert_top_no_gpio_R9: assert property (@(posedge clk) disable iff (rst)
        pin_oe[TOP]);
    assert_unknown_high_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && (cfg_code[TOP*CODE_W +: CODE_W] > CODE_LAST)) |-> pin_out[TOP]);
endmodule

bind ctl_pin_mux ctl_pin_mux_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_valid      (cfg_valid),
    .cfg_code       (cfg_code),
    .usb_configured (usb_configured),
    .usb_suspend    (usb_suspend),
    .uart_tx_busy   (uart_tx_busy),
    .out_xfer_evt   (out_xfer_evt),
    .in_xfer_evt    (in_xfer_evt),
    .sleep_n        (sleep_n),
    .pwren_n        (pwren_n),
    .txen           (txen_q),
    .led_n          (led_n),
    .div_cnt        (div_q),
    .pin_out        (pin_out),
    .pin_oe         (pin_oe)
);

// File: tb/tb_ctl_pin_mux.sv
`timescale 1ns/100ps
module tb_ctl_pin_mux;
    localparam int NP   = 5;
    localparam int NG   = 4;
    localparam int HOLD = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_valid;
    logic [NP*4-1:0] cfg_code;
    logic          usb_configured, usb_suspend, uart_tx_busy;
    logic          out_xfer_evt, in_xfer_evt;
    logic [NG-1:0] gpio_out, gpio_oe;
    logic [NP-1:0] pin_out, pin_oe;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    bit done     = 0;

    ctl_pin_mux #(.NUM_PINS(NP), .NUM_GPIO(NG), .LED_HOLD(HOLD)) dut (.*);

    always #2.5 clk = ~clk;

    // Behavioural model: timestamps and a run length.
    int cyc = 0;
    int last_out = -1000, last_in = -1000, last_any = -1000;
    int run = 0;
    bit sus_m = 0, cfgd_m = 0, busy_m = 0, gate_m = 0;

    always @(posedge clk) begin
        if (rst) begin
            last_out = -1000; last_in = -1000; last_any = -1000;
            run = 0; sus_m = 0; cfgd_m = 0; busy_m = 0;
        end else begin
            cyc++;
            if (out_xfer_evt) last_out = cyc;
            if (in_xfer_evt)  last_in  = cyc;
            if (out_xfer_evt || in_xfer_evt) last_any = cyc;
            run    = sus_m ? 0 : run + 1;
            sus_m  = usb_suspend;
            cfgd_m = usb_configured;
            busy_m = uart_tx_busy;
        end
    end

    always @(negedge clk) begin
        gate_m = rst ? 1'b0 : !sus_m;
    end

    function automatic int dflt(input int p);
        case (p)
            0: return 2;
            1: return 3;
            2: return 0;
            3: return 1;
            default: return 5;
        endcase
    endfunction

    function automatic string req_of(input int code, input int p);
        if (!cfg_valid) return "R1";
        case (code)
            0: return "R6";
            1: return "R5";
            2, 3, 4: return "R2";
            5: return "R4";
            6: return "R8";
            7, 8, 9: return "R7";
            10: return (p < NG) ? "R9" : "R10";
            default: return "R10";
        endcase
    endfunction

    task automatic compare_pins();
        for (int p = 0; p < NP; p++) begin
            int  code;
            bit  eo, ee;
            code = cfg_valid ? int'(cfg_code[p*4 +: 4]) : dflt(p);
            ee = 1'b1;
            case (code)
                0: eo = busy_m;
                1: eo = !(cfgd_m && !sus_m);
                2: eo = !((cyc - last_out) < HOLD);
                3: eo = !((cyc - last_in) < HOLD);
                4: eo = !((cyc - last_any) < HOLD);
                5: eo = !sus_m;
                6: eo = clk & gate_m;
                7: eo = run[0];
                8: eo = run[1];
                9: eo = run[2];
                10: begin
                    if (p < NG) begin eo = gpio_out[p]; ee = gpio_oe[p]; end
                    else eo = 1'b1;
                end
                default: eo = 1'b1;
            endcase
            vec_cnt++;
            if (pin_out[p] !== eo || pin_oe[p] !== ee) begin
                miss_cnt++;
                $display("FAIL %s pin %0d code %0d t=%0t: out/oe=%b%b expected %b%b",
                         req_of(code, p), p, code, $time, pin_out[p], pin_oe[p], eo, ee);
            end
        end
    endtask

    always @(posedge clk) begin #1; if (!done) compare_pins(); end
    always @(negedge clk) begin #1; if (!done) compare_pins(); end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_out();
        out_xfer_evt = 1; step(1); out_xfer_evt = 0;
    endtask

    task automatic pulse_in();
        in_xfer_evt = 1; step(1); in_xfer_evt = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        miss_cnt++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        rst = 1; cfg_valid = 0; cfg_code = '1;
        usb_configured = 0; usb_suspend = 0; uart_tx_busy = 0;
        out_xfer_evt = 0; in_xfer_evt = 0; gpio_out = '0; gpio_oe = '0;
        step(3);
        // R11: reset state under the default map
        vec_cnt++;
        if (pin_out !== 5'b11011 || pin_oe !== 5'b11111) begin
            miss_cnt++;
            $display("FAIL R11 reset: out=%b oe=%b expected 11011 11111", pin_out, pin_oe);
        end
        rst = 0;
        // R1 default map with garbage codes present; R2 LEDs, R6, R5, R4
        step(2);  pulse_out(); step(15);
        pulse_in(); step(15);
        uart_tx_busy = 1; step(6); uart_tx_busy = 0; step(3);
        usb_configured = 1; step(4);
        usb_suspend = 1; step(5); usb_suspend = 0; step(3);
        // R3: retrigger during a running pulse
        pulse_out(); step(6); pulse_out(); step(8); pulse_in(); step(3); pulse_in(); step(20);
        // R7 / R8: clocks, with suspend stop and restart; R2 combined LED on pin 4
        cfg_valid = 1;
        cfg_code = {4'd4, 4'd9, 4'd8, 4'd7, 4'd6};
        step(20);
        usb_suspend = 1; step(9); usb_suspend = 0; step(20);
        pulse_out(); step(3); pulse_in(); step(20);
        // R9: GPIO on pins 0..3; pin 4 rejects it
        cfg_code = {5{4'd10}};
        for (int v = 0; v < 16; v += 3) begin
            gpio_out = v[3:0]; gpio_oe = ~v[3:0]; step(2);
        end
        // Shuffled functions: R5, R6, R4, R2
        cfg_code = {4'd5, 4'd0, 4'd1, 4'd3, 4'd2};
        uart_tx_busy = 1; pulse_in(); step(4); uart_tx_busy = 0; pulse_out(); step(4);
        usb_suspend = 1; step(3); usb_configured = 0; step(2); usb_suspend = 0; step(3);
        usb_configured = 1; step(16);
        // R10: unrecognised codes
        cfg_code = {4'd15, 4'd14, 4'd13, 4'd12, 4'd11}; step(4);
        cfg_code = {4'd11, 4'd12, 4'd13, 4'd14, 4'd15}; step(4);
        // R11: reset in the middle of clocking and an LED pulse
        cfg_code = {4'd4, 4'd9, 4'd8, 4'd7, 4'd6};
        step(5); pulse_out(); step(2);
        rst = 1; step(2); rst = 0; step(12);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end
endmodule